// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block is the CPU-facing register set of a PC-style parallel printer port. A small offset address selects one of three registers: a data register that drives the eight port data pins, a read-only status byte assembled from the peripheral handshake inputs, and a control register that drives the four host-side handshake outputs. Bus accesses take one cycle. Address, write enable and read enable are sampled on the clock edge, and read data is combinational from the selected register.

A 3-bit mode input sets what the data offset does. The encoding is 000 standard, 001 bidirectional, 010 data FIFO, 011 extended capability, 100 enhanced parallel, 101 reserved, 110 test and 111 configuration. In the standard and bidirectional modes the data offset is a plain pin latch. In extended-capability mode, a write to the data offset is pushed into a 16-entry transmit FIFO and tagged as an address/run-length byte. A forward-channel engine outside this block pops the FIFO.

Top module: `parport_host_regs`

## Requirements
- R1: After reset the data register and control bits 5:0 are zero. The block then drives pdOut=0x00, pdOe=1, nStrobe=1, nAutoFd=1, nInit=0 and nSelectIn=1, with fifoEmpty=1 and fifoFull=0.
- R2: In modes 000 and 001, a write to offset 0 updates pdOut with the written byte in the following cycle. A read at offset 0 returns the present levels on pdIn.
- R3: A read at offset 1 returns status bit7 = NOT busy, bit6 = nAck, bit5 = pError, bit4 = select, bit3 = nFault, and bits 2:0 = 0.
- R4: A write to offset 2 stores bits 5:0. A read at offset 2 returns those six bits, with bits 7:6 reading 0.
- R5: nStrobe is the inverse of control bit 0, nAutoFd the inverse of bit 1, nSelectIn the inverse of bit 3, and nInit equals bit 2 without inversion.
- R6: pdOe is 0 when the mode is 001 and control bit 5 (direction) is 1. Otherwise pdOe is 1.
- R7: In mode 011 with direction 0, a write to offset 0 pushes the 9-bit entry {1'b1, byte} into the FIFO (bit 8 = 1 marks address/run-length). It leaves pdOut unchanged. The oldest entry appears on fifoHead.
- R8: In mode 011 with direction 1, a write to offset 0 is ignored: nothing is pushed and pdOut does not change.
- R9: Entries leave the FIFO in the order they were written. fifoFull rises when 16 entries are held, and a push while full is dropped. A pulse on fifoPop removes the head entry.
- R10: Any cycle spent in mode 000 or 001 empties the FIFO by the following cycle.
- R11: In modes 010, 100, 101, 110 and 111, a write to offset 0 changes neither pdOut nor the FIFO.
- R12: Offset 3 reads as 0x00 and ignores writes. busRdData is 0x00 whenever busRdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Port mode select |
| busAddr | input | 2 | Register offset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| pdIn | input | 8 | Levels sensed on the port data pins |
| pdOut | output | 8 | Data driven toward the port pins |
| pdOe | output | 1 | Data pin output enable |
| nFault | input | 1 | Peripheral fault, active low |
| select | input | 1 | Peripheral selected |
| pError | input | 1 | Paper error |
| nAck | input | 1 | Acknowledge, active low |
| busy | input | 1 | Peripheral busy |
| nStrobe | output | 1 | Strobe, active low |
| nAutoFd | output | 1 | Auto line feed, active low |
| nInit | output | 1 | Initialise, active low |
| nSelectIn | output | 1 | Select peripheral, active low |
| fifoPop | input | 1 | Removes the FIFO head entry |
| fifoHead | output | 9 | Oldest FIFO entry, bit 8 is the tag |
| fifoFull | output | 1 | FIFO holds 16 entries |
| fifoEmpty | output | 1 | FIFO holds nothing |

## Verification
The properties take for granted that bus strobes and the mode input change only between clock edges. They also assume that the mode stays fixed across the cycle after a control write whose effect on pdOe is being checked. The stimulus drives every input one time unit after a rising edge and keeps each strobe high for exactly one cycle. It holds the mode steady around every access it inspects and changes the mode only in its own idle cycles.

// File: rtl/parport_pkg.sv
package parport_pkg;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_DFIFO = 3'b010,
    MODE_EXT   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_RSVD  = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } portMode_t;

  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  localparam int CTRL_DIR_BIT = 5;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_t;

  // Strobes handed from the decode to the datapath
  typedef struct packed {
    logic   wrData;
    logic   wrCtrl;
    logic   fifoPush;
    logic   fifoFlush;
    logic   padRelease;
    logic   rdEn;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/parport_ctrl.sv
module parport_ctrl
  import parport_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [2:0]        mode,
  input  logic              dirBit,
  output regStrobe_t        strobes
);

  portMode_t modeDec;
  logic      latchMode;
  logic      hitData;
  logic      hitCtrl;

  assign modeDec   = portMode_t'(mode);
  assign latchMode = (modeDec == MODE_STD) || (modeDec == MODE_BIDIR);
  assign hitData   = (busAddr == ADDR_W'(OFS_DATA));
  assign hitCtrl   = (busAddr == ADDR_W'(OFS_CTRL));

  always_comb begin
    strobes            = '0;
    strobes.wrData     = busWrEn && hitData && latchMode;
    strobes.wrCtrl     = busWrEn && hitCtrl;
    strobes.fifoPush   = busWrEn && hitData && (modeDec == MODE_EXT) && !dirBit;
    strobes.fifoFlush  = latchMode;
    strobes.padRelease = (modeDec == MODE_BIDIR) && dirBit;
    strobes.rdEn       = busRdEn;
    if (busAddr == ADDR_W'(OFS_DATA))      strobes.rdSel = SEL_DATA;
    else if (busAddr == ADDR_W'(OFS_STAT)) strobes.rdSel = SEL_STAT;
    else if (busAddr == ADDR_W'(OFS_CTRL)) strobes.rdSel = SEL_CTRL;
    else                                   strobes.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/parport_txfifo.sv
module parport_txfifo #(
  parameter int ENTRY_W = 9,
  parameter int DEPTH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               push,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               full,
  output logic               empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;
  logic               pushOk;
  logic               popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/parport_dpath.sv
module parport_dpath
  import parport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CTRL_W     = 6,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] pdIn,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOe,
  input  logic              nFault,
  input  logic              select,
  input  logic              pError,
  input  logic              nAck,
  input  logic              busy,
  output logic              nStrobe,
  output logic              nAutoFd,
  output logic              nInit,
  output logic              nSelectIn,
  output logic              dirBit,
  input  logic              fifoPop,
  output logic [DATA_W:0]   fifoHead,
  output logic              fifoFull,
  output logic              fifoEmpty
);

  localparam int ENTRY_W = DATA_W + 1;
  localparam int PAD_W   = DATA_W - CTRL_W;
  localparam int STAT_LO = DATA_W - 5;

  logic [DATA_W-1:0] dataReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobes.wrData) dataReg <= busWrData;
      if (strobes.wrCtrl) ctrlReg <= busWrData[CTRL_W-1:0];
    end
  end

  assign pdOut     = dataReg;
  assign pdOe      = !strobes.padRelease;
  assign dirBit    = ctrlReg[CTRL_DIR_BIT];
  assign nStrobe   = !ctrlReg[0];
  assign nAutoFd   = !ctrlReg[1];
  assign nInit     = ctrlReg[2];
  assign nSelectIn = !ctrlReg[3];

  assign statusByte = {!busy, nAck, pError, select, nFault, {STAT_LO{1'b0}}};

  always_comb begin
    unique case (strobes.rdSel)
      SEL_DATA: rdMux = pdIn;
      SEL_STAT: rdMux = statusByte;
      SEL_CTRL: rdMux = {{PAD_W{1'b0}}, ctrlReg};
      default:  rdMux = '0;
    endcase
  end

  assign busRdData = strobes.rdEn ? rdMux : '0;

  parport_txfifo #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (FIFO_DEPTH)
  ) i_txfifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.fifoFlush),
    .push     (strobes.fifoPush),
    .pushData ({1'b1, busWrData}),
    .pop      (fifoPop),
    .head     (fifoHead),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

endmodule

// File: rtl/parport_host_regs.sv
module parport_host_regs
  import parport_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 8,
  parameter int CTRL_W     = 6,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] pdIn,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOe,
  input  logic              nFault,
  input  logic              select,
  input  logic              pError,
  input  logic              nAck,
  input  logic              busy,
  output logic              nStrobe,
  output logic              nAutoFd,
  output logic              nInit,
  output logic              nSelectIn,
  input  logic              fifoPop,
  output logic [DATA_W:0]   fifoHead,
  output logic              fifoFull,
  output logic              fifoEmpty
);

  regStrobe_t strobes;
  logic       dirBit;

  parport_ctrl #(
    .ADDR_W (ADDR_W)
  ) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .mode    (mode),
    .dirBit  (dirBit),
    .strobes (strobes)
  );

  parport_dpath #(
    .DATA_W     (DATA_W),
    .CTRL_W     (CTRL_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pdIn      (pdIn),
    .pdOut     (pdOut),
    .pdOe      (pdOe),
    .nFault    (nFault),
    .select    (select),
    .pError    (pError),
    .nAck      (nAck),
    .busy      (busy),
    .nStrobe   (nStrobe),
    .nAutoFd   (nAutoFd),
    .nInit     (nInit),
    .nSelectIn (nSelectIn),
    .dirBit    (dirBit),
    .fifoPop   (fifoPop),
    .fifoHead  (fifoHead),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty)
  );

endmodule

// File: rtl/parport_chk.sv
module parport_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] pdIn,
  input logic [DATA_W-1:0] pdOut,
  input logic              pdOe,
  input logic              busy,
  input logic              nStrobe,
  input logic              nAutoFd,
  input logic              nInit,
  input logic              nSelectIn,
  input logic              fifoPop,
  input logic [DATA_W:0]   fifoHead,
  input logic              fifoFull,
  input logic              fifoEmpty
);

  p_data_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(0) && mode[2:1] == 2'b00) |=> (pdOut == $past(busWrData)));

  p_status_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(1)) |-> (busRdData[2:0] == 3'b000 && busRdData[7] == !busy));

  p_ctrl_top_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(2)) |-> (busRdData[7:6] == 2'b00));

  p_pin_polarity_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(2)) |=>
      (nStrobe == !$past(busWrData[0]) && nAutoFd == !$past(busWrData[1]) &&
       nInit == $past(busWrData[2]) && nSelectIn == !$past(busWrData[3])));

  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(2) && busWrData[5] && mode == 3'b001) ##1 (mode == 3'b001)
      |-> !pdOe);

  p_ext_keeps_pins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(0) && mode == 3'b011) |=> $stable(pdOut));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !fifoPop && mode == 3'b011) |=> (fifoFull && $stable(fifoHead)));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  p_held_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2:1] == 2'b00) |=> fifoEmpty);

  p_idle_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0));

endmodule

bind parport_host_regs parport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_parport_host_regs.sv
`timescale 1ns/1ps
module test_parport_host_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] pdIn;
  logic [7:0] pdOut;
  logic       pdOe;
  logic       nFault = 1'b1, select = 1'b0, pError = 1'b0, nAck = 1'b1, busy = 1'b0;
  logic       nStrobe, nAutoFd, nInit, nSelectIn;
  logic       fifoPop = 1'b0;
  logic [8:0] fifoHead;
  logic       fifoFull, fifoEmpty;
  logic [7:0] extBus = 8'h00;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      reqQ[$];

  always #2.5 clk = ~clk;

  assign pdIn = pdOe ? pdOut : extBus;

  parport_host_regs i_parport_host_regs (.*);

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: reads are compared mid-cycle against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && busRdEn) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual=%h expected=none", busRdData);
      end else begin
        check(reqQ.pop_front(), {1'b0, busRdData}, {1'b0, expQ.pop_front()});
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    @(posedge clk); #1;
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp); reqQ.push_back(req);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic pop1();
    @(posedge clk); #1; fifoPop = 1'b1;
    @(posedge clk); #1; fifoPop = 1'b0;
  endtask

  task automatic setMode(logic [2:0] m);
    @(posedge clk); #1; mode = m;
    @(posedge clk); #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset values
    check("R1 pdOut", {1'b0, pdOut}, 9'h000);
    check("R1 pins", {5'b0, nStrobe, nAutoFd, nInit, nSelectIn}, 9'b0_0000_1101);
    check("R1 flags", {6'b0, pdOe, fifoEmpty, fifoFull}, 9'b110);
    rd(2'd2, 8'h00, "R1 ctrl");

    // R2 data latch in standard mode
    wr(2'd0, 8'hA5);
    check("R2 pdOut", {1'b0, pdOut}, 9'h0A5);
    rd(2'd0, 8'hA5, "R2 read");
    wr(2'd0, 8'h3C);
    rd(2'd0, 8'h3C, "R2 read2");

    // R3 status patterns
    @(posedge clk); #1;
    busy = 1; nAck = 0; pError = 1; select = 0; nFault = 1;
    rd(2'd1, 8'h28, "R3 pattern1");
    busy = 0; nAck = 1; pError = 0; select = 1; nFault = 0;
    rd(2'd1, 8'hD0, "R3 pattern2");

    // R4, R5 control register and pin polarity
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h3F, "R4 ctrl");
    check("R5 pins all", {5'b0, nStrobe, nAutoFd, nInit, nSelectIn}, 9'b0_0000_0010);
    check("R6 std oe", {8'b0, pdOe}, 9'h001);
    wr(2'd2, 8'h05);
    check("R5 pins 05", {5'b0, nStrobe, nAutoFd, nInit, nSelectIn}, 9'b0_0000_0111);
    rd(2'd2, 8'h05, "R4 ctrl05");

    // R6 direction release in bidirectional mode
    setMode(3'b001);
    extBus = 8'h5A;
    wr(2'd2, 8'h20);
    check("R6 release", {8'b0, pdOe}, 9'h000);
    rd(2'd0, 8'h5A, "R6 ext read");
    wr(2'd0, 8'h77);
    check("R2 bidir latch", {1'b0, pdOut}, 9'h077);
    wr(2'd2, 8'h00);
    check("R6 drive", {8'b0, pdOe}, 9'h001);
    rd(2'd0, 8'h77, "R2 bidir read");

    // R7 tagged push in extended mode
    setMode(3'b011);
    wr(2'd0, 8'h11);
    check("R7 head", fifoHead, 9'h111);
    check("R7 nonempty", {8'b0, fifoEmpty}, 9'h000);
    check("R7 pins kept", {1'b0, pdOut}, 9'h077);
    wr(2'd0, 8'h22);
    pop1();
    check("R7 order", fifoHead, 9'h122);
    pop1();
    check("R7 empty", {8'b0, fifoEmpty}, 9'h001);

    // R8 reverse direction write ignored
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h99);
    check("R8 no push", {8'b0, fifoEmpty}, 9'h001);
    check("R8 pins", {1'b0, pdOut}, 9'h077);
    wr(2'd2, 8'h00);

    // R9 fill, overflow drop, order
    for (int i = 0; i < 17; i++) wr(2'd0, 8'(8'h40 + i));
    check("R9 full", {8'b0, fifoFull}, 9'h001);
    for (int i = 0; i < 16; i++) begin
      check("R9 order", fifoHead, {1'b1, 8'(8'h40 + i)});
      pop1();
    end
    check("R9 drop", {7'b0, fifoEmpty, fifoFull}, 9'b10);

    // R10 flush by standard mode
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h03);
    @(posedge clk); #1 mode = 3'b000;
    @(posedge clk); #1 mode = 3'b011;
    check("R10 flushed", {8'b0, fifoEmpty}, 9'h001);
    @(posedge clk); #1;
    check("R10 stays", {8'b0, fifoEmpty}, 9'h001);

    // R11 other modes ignore data writes
    setMode(3'b100);
    wr(2'd0, 8'hEE);
    check("R11 epp", {7'b0, fifoEmpty, (pdOut == 8'h77)}, 9'b11);
    setMode(3'b010);
    wr(2'd0, 8'hDD);
    check("R11 dfifo", {7'b0, fifoEmpty, (pdOut == 8'h77)}, 9'b11);
    setMode(3'b111);
    wr(2'd0, 8'hCC);
    check("R11 cfg", {7'b0, fifoEmpty, (pdOut == 8'h77)}, 9'b11);

    // R12 unused offset and idle read
    setMode(3'b000);
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R12 ofs3");
    rd(2'd2, 8'h00, "R12 ctrl kept");
    @(negedge clk);
    check("R12 idle", {1'b0, busRdData}, 9'h000);

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    finish();
  end

endmodule